// File: doc/BRIEF.md
# Multi-bank SRAM chip-select controller

This block decodes each processor access against eight programmable bank descriptors and runs a static-memory strobe sequence for the winning bank. A descriptor gives a bank its base address and a power-of-two block size from 32 KiB to 64 MiB. It also holds a port width, an address-type qualifier (a value and a mask), a wait-state count and an enable bit. When a request hits, the controller raises that bank's select. It drives four byte enables from the access size, the low address bits and the port width. It raises the output enable for reads only, holds these strobes for the programmed length and signals completion with a one-cycle acknowledge. A request that hits no bank completes with a one-cycle unmapped flag and no strobes.

Requests enter on a valid/ready handshake. `req_ready` is high only while the controller is idle. A request transfers on a rising edge where both `req_valid` and `req_ready` are high, and its address, type, direction and size are sampled at that edge. While `req_ready` is low, the requester must hold `req_valid` and the request fields unchanged. The controller never drops a transfer and never takes a second request before the current one has finished. `req_ready` returns high in the cycle after the acknowledge or the unmapped flag. Descriptors are written through a plain one-cycle write port.

Bank 0 comes out of reset already enabled as a boot select. It covers the whole address space, accepts every access type and uses the maximum wait count, so code can be fetched before any setup.

Top module: `cs_sram_ctl`

## Requirements
- R1: After reset, bank 0 is enabled with base 0 and size code 11 (the full 64 MiB space). Its type mask is 0, its port is 32 bits and its wait count is 30. Banks 1 to 7 are disabled. `req_ready` is 1, and `cs_sel`, `be`, `oe`, `ack` and `unmapped` are 0.
- R2: Bank b hits when three conditions hold. It is enabled. Address bits [25:15+c] equal the same bits of its base, where c is the size code clamped to 11, so the size is 32 KiB << c. And ((req_type XOR tval) AND tmask) is 0. A disabled bank never hits.
- R3: When several banks hit, only the lowest-numbered one is selected; at most one `cs_sel` bit is ever high.
- R4: A hit holds the bank's `cs_sel` bit for W+2 cycles, starting the cycle after acceptance, where W is the wait field and a field of 31 counts as 30. `ack` is high in the last of these cycles only, once per access.
- R5: A request that hits no bank raises `unmapped` for exactly the cycle after acceptance, with `cs_sel`, `be`, `oe` and `ack` all 0.
- R6: `oe` equals `req_read` of the accepted request during its select window and is 0 otherwise.
- R7: During the select window, `be` follows a fixed rule. Let m be 0001 for size 0, 0011 for size 1 and 1111 for sizes 2 and 3. Let the lane mask k be 0 for port code 0 (8-bit), 1 for port code 1 (16-bit) and 3 for port codes 2 and 3 (32-bit). Let the port lanes p be 0001, 0011 and 1111 for those same port codes. Then `be` = ((m << (addr[1:0] AND k)) AND p), truncated to 4 bits. Outside the window, `be` is 0.
- R8: `req_ready` is high only while the controller is idle. The controller accepts nothing from acceptance until the cycle after `ack` or `unmapped`.
- R9: The write port addresses descriptors as `cfg_addr` = {bank, word}.
  - Word 0 holds the base in bits [25:15], the enable in bit 4 and the size code in bits [3:0].
  - Word 1 holds the wait count in bits [4:0], the port code in bits [9:8], the type value in bits [18:16] and the type mask in bits [22:20].
  - A write takes effect at its clock edge. A request accepted at that same edge is decoded with the old descriptor.
  - The wait count is captured at acceptance, so a later write never changes an access in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can transfer |
| req_addr | input | 26 | Byte address |
| req_type | input | 3 | Access type code matched against the qualifier |
| req_read | input | 1 | 1 for read, 0 for write |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_addr | input | 4 | {bank[2:0], word} |
| cfg_wdata | input | 32 | Descriptor write data |
| cs_sel | output | 8 | One-hot bank select |
| be | output | 4 | Byte-lane enables |
| oe | output | 1 | Output enable (reads) |
| ack | output | 1 | Access complete, last select cycle |
| unmapped | output | 1 | No bank matched |

## Verification
A descriptor write and the acceptance of a request that decodes through the same descriptor can share one clock edge. The same holds for a write to the wait count of the bank whose access is still in flight. The bench provokes the first case by driving `cfg_we` and `req_valid` in the same cycle: it rewrites a bank's wait count or disables the bank, and it requires the select length and the hit to follow the old values. It provokes the second case by rewriting the wait count during the select window, and it requires the running access to keep its length while the next access takes the new one.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_AW     = 26;
  localparam int CS_MINLG  = 15;
  localparam int CS_MAXCODE = 11;
  localparam int CS_CODEW  = 4;
  localparam int CS_WSW    = 5;
  localparam int CS_WSMAX  = 30;
  localparam int CS_TW     = 3;
  localparam int CS_NBE    = 4;
  localparam int CS_CFGW   = 32;
  localparam int CS_BASEW  = CS_AW - CS_MINLG;

  localparam int F_VALID = 4;
  localparam int F_PORT  = 8;
  localparam int F_TVAL  = 16;
  localparam int F_TMASK = 20;

  typedef struct packed {
    logic                  valid;
    logic [CS_BASEW-1:0]   base;
    logic [CS_CODEW-1:0]   code;
    logic [1:0]            port;
    logic [CS_TW-1:0]      tval;
    logic [CS_TW-1:0]      tmask;
    logic [CS_WSW-1:0]     ws;
  } desc_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_MISS = 2'd2
  } acc_st_t;

  function automatic desc_t boot_desc();
    desc_t d;
    d       = '0;
    d.valid = 1'b1;
    d.code  = CS_CODEW'(CS_MAXCODE);
    d.port  = 2'd2;
    d.ws    = CS_WSW'(CS_WSMAX);
    return d;
  endfunction
endpackage

// File: rtl/cs_desc_regs.sv
module cs_desc_regs
  import cs_pkg::*;
#(
  parameter int NBANK = 8,
  localparam int BSELW = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [BSELW:0]        cfg_addr,
  input  logic [CS_CFGW-1:0]    cfg_wdata,
  output desc_t [NBANK-1:0]     desc_o
);
  desc_t [NBANK-1:0] desc_q;
  logic [BSELW-1:0]  bk;
  logic              unused_cfg_bits;

  assign bk = cfg_addr[BSELW:1];
  assign unused_cfg_bits = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++)
        desc_q[b] <= (b == 0) ? boot_desc() : desc_t'('0);
    end else if (cfg_we && (int'(bk) < NBANK)) begin
      if (!cfg_addr[0]) begin
        desc_q[bk].base  <= cfg_wdata[CS_AW-1:CS_MINLG];
        desc_q[bk].valid <= cfg_wdata[F_VALID];
        desc_q[bk].code  <= cfg_wdata[CS_CODEW-1:0];
      end else begin
        desc_q[bk].ws    <= cfg_wdata[CS_WSW-1:0];
        desc_q[bk].port  <= cfg_wdata[F_PORT +: 2];
        desc_q[bk].tval  <= cfg_wdata[F_TVAL +: CS_TW];
        desc_q[bk].tmask <= cfg_wdata[F_TMASK +: CS_TW];
      end
    end
  end

  assign desc_o = desc_q;
endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match
  import cs_pkg::*;
(
  input  desc_t              desc_i,
  input  logic [CS_AW-1:0]   addr_i,
  input  logic [CS_TW-1:0]   type_i,
  output logic               hit_o
);
  logic [CS_CODEW-1:0] code_eff;
  logic                addr_ok;
  logic                type_ok;
  logic                unused_desc_bits;

  assign unused_desc_bits = ^{desc_i.port, desc_i.ws, addr_i[CS_MINLG-1:0]};

  always_comb begin
    code_eff = (int'(desc_i.code) > CS_MAXCODE) ? CS_CODEW'(CS_MAXCODE) : desc_i.code;
    addr_ok  = 1'b1;
    for (int i = 0; i < CS_BASEW; i++) begin
      if ((i >= int'(code_eff)) && (addr_i[i+CS_MINLG] != desc_i.base[i]))
        addr_ok = 1'b0;
    end
    type_ok = ((type_i ^ desc_i.tval) & desc_i.tmask) == '0;
    hit_o   = desc_i.valid && addr_ok && type_ok;
  end
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel #(
  parameter int NBANK = 8
)(
  input  logic [NBANK-1:0] hit_i,
  output logic [NBANK-1:0] sel_o,
  output logic             any_o
);
  always_comb begin
    sel_o = '0;
    any_o = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (hit_i[b] && !any_o) begin
        sel_o[b] = 1'b1;
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cs_lane_gen.sv
module cs_lane_gen
  import cs_pkg::*;
(
  input  logic [1:0]        size_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        port_i,
  output logic [CS_NBE-1:0] be_o
);
  logic [CS_NBE-1:0] width_m;
  logic [1:0]        lane_k;
  logic [CS_NBE-1:0] port_l;
  logic [1:0]        shift;

  always_comb begin
    case (size_i)
      2'd0:    width_m = 4'b0001;
      2'd1:    width_m = 4'b0011;
      default: width_m = 4'b1111;
    endcase
    case (port_i)
      2'd0:    begin lane_k = 2'd0; port_l = 4'b0001; end
      2'd1:    begin lane_k = 2'd1; port_l = 4'b0011; end
      default: begin lane_k = 2'd3; port_l = 4'b1111; end
    endcase
    shift = off_i & lane_k;
    be_o  = (width_m << shift) & port_l;
  end
endmodule

// File: rtl/cs_access_fsm.sv
module cs_access_fsm
  import cs_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int WS_MAX = CS_WSMAX
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              hit_any_i,
  input  logic [NBANK-1:0]  sel_i,
  input  logic [CS_NBE-1:0] be_i,
  input  logic              read_i,
  input  logic [CS_WSW-1:0] ws_i,
  output logic [NBANK-1:0]  sel_o,
  output logic [CS_NBE-1:0] be_o,
  output logic              oe_o,
  output logic              ack_o,
  output logic              miss_o,
  output logic              idle_o
);
  acc_st_t           st_q;
  logic [CS_WSW-1:0] cnt_q;
  logic [CS_WSW-1:0] ws_eff;

  assign ws_eff = (int'(ws_i) > WS_MAX) ? CS_WSW'(WS_MAX) : ws_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      sel_o <= '0;
      be_o  <= '0;
      oe_o  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept_i) begin
          if (hit_any_i) begin
            st_q  <= ST_BUSY;
            cnt_q <= ws_eff + CS_WSW'(1);
            sel_o <= sel_i;
            be_o  <= be_i;
            oe_o  <= read_i;
          end else begin
            st_q  <= ST_MISS;
          end
        end
        ST_BUSY: if (cnt_q == '0) begin
          st_q  <= ST_IDLE;
          sel_o <= '0;
          be_o  <= '0;
          oe_o  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - CS_WSW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_o  = (st_q == ST_BUSY) && (cnt_q == '0);
  assign miss_o = (st_q == ST_MISS);
  assign idle_o = (st_q == ST_IDLE);
endmodule

// File: rtl/cs_sram_ctl.sv
module cs_sram_ctl
  import cs_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int WS_MAX = CS_WSMAX,
  localparam int BSELW = (NBANK > 1) ? $clog2(NBANK) : 1
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CS_AW-1:0]    req_addr,
  input  logic [CS_TW-1:0]    req_type,
  input  logic                req_read,
  input  logic [1:0]          req_size,
  input  logic                cfg_we,
  input  logic [BSELW:0]      cfg_addr,
  input  logic [CS_CFGW-1:0]  cfg_wdata,
  output logic [NBANK-1:0]    cs_sel,
  output logic [CS_NBE-1:0]   be,
  output logic                oe,
  output logic                ack,
  output logic                unmapped
);
  desc_t [NBANK-1:0]  desc;
  logic [NBANK-1:0]   hit;
  logic [NBANK-1:0]   win;
  logic               hit_any;
  logic [CS_WSW-1:0]  ws_win;
  logic [1:0]         port_win;
  logic [CS_NBE-1:0]  be_next;
  logic               accept;

  cs_desc_regs #(.NBANK(NBANK)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .desc_o(desc)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    cs_bank_match u_match (
      .desc_i(desc[g]), .addr_i(req_addr), .type_i(req_type), .hit_o(hit[g])
    );
  end

  cs_prio_sel #(.NBANK(NBANK)) u_prio (
    .hit_i(hit), .sel_o(win), .any_o(hit_any)
  );

  always_comb begin
    ws_win   = '0;
    port_win = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (win[b]) begin
        ws_win   = ws_win | desc[b].ws;
        port_win = port_win | desc[b].port;
      end
    end
  end

  cs_lane_gen u_lanes (
    .size_i(req_size), .off_i(req_addr[1:0]), .port_i(port_win), .be_o(be_next)
  );

  assign accept = req_valid && req_ready;

  cs_access_fsm #(.NBANK(NBANK), .WS_MAX(WS_MAX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .hit_any_i(hit_any),
    .sel_i(win), .be_i(be_next), .read_i(req_read), .ws_i(ws_win),
    .sel_o(cs_sel), .be_o(be), .oe_o(oe), .ack_o(ack), .miss_o(unmapped),
    .idle_o(req_ready)
  );
endmodule

// File: rtl/cs_sram_ctl_chk.sv
module cs_sram_ctl_chk
  import cs_pkg::*;
#(
  parameter int NBANK  = 8,
  parameter int WS_MAX = CS_WSMAX
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NBANK-1:0]  cs_sel,
  input logic [CS_NBE-1:0] be,
  input logic              oe,
  input logic              ack,
  input logic              unmapped
);
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) run_len <= '0;
    else if (|cs_sel && !ack) run_len <= run_len + 8'd1;
    else run_len <= '0;
  end

  // R3: never two selects
  a_r3_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs_sel));
  // R4: acknowledge only inside a select window, then the select drops
  a_r4_ack_in_window: assert property (@(posedge clk) disable iff (!rst_n) ack |-> (|cs_sel));
  a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n) ack |=> (cs_sel == '0));
  a_r4_sel_steady: assert property (@(posedge clk) disable iff (!rst_n) (|cs_sel && !ack) |=> $stable(cs_sel));
  a_r4_max_len: assert property (@(posedge clk) disable iff (!rst_n) (|cs_sel) |-> (int'(run_len) <= WS_MAX + 1));
  // R5: unmapped is a lone pulse with no strobes
  a_r5_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n) unmapped |-> (cs_sel == '0 && !ack && !oe && be == '0));
  a_r5_miss_pulse: assert property (@(posedge clk) disable iff (!rst_n) unmapped |=> !unmapped);
  // R6 / R7: strobes only inside the window
  a_r6_oe_window: assert property (@(posedge clk) disable iff (!rst_n) oe |-> (|cs_sel));
  a_r7_be_window: assert property (@(posedge clk) disable iff (!rst_n) (|be) |-> (|cs_sel));
  // R8: idle means nothing in flight; a transfer always yields a response
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (cs_sel == '0 && !unmapped));
  a_r8_accept_resp: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> (|cs_sel || unmapped));
endmodule

bind cs_sram_ctl cs_sram_ctl_chk #(.NBANK(NBANK), .WS_MAX(WS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cs_sel(cs_sel), .be(be), .oe(oe), .ack(ack), .unmapped(unmapped)
);

// File: tb/sim_cs_sram_ctl.sv
`timescale 1ns/1ps
module sim_cs_sram_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [25:0] req_addr = '0;
  logic [2:0]  req_type = '0;
  logic        req_read = 1'b0;
  logic [1:0]  req_size = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  cs_sel;
  logic [3:0]  be;
  logic        oe, ack, unmapped;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cs_sram_ctl u0 (.*);

  // bench-side mirror of what was programmed
  bit          m_valid[8];
  logic [25:0] m_base[8];
  int          m_code[8], m_port[8], m_tval[8], m_tmask[8], m_ws[8];

  // observation of the last access
  int   o_len, o_ack_at, o_acks;
  logic [7:0] o_sel;
  logic [3:0] o_be;
  logic o_oe, o_unm, o_ack0, o_ready_bad, o_strobe_bad;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_bank(logic [25:0] a, int t);
    for (int b = 0; b < 8; b++) begin
      int cc = (m_code[b] > 11) ? 11 : m_code[b];
      int sh = 15 + cc;
      if (m_valid[b] && ((a >> sh) == (m_base[b] >> sh)) && (((t ^ m_tval[b]) & m_tmask[b]) == 0))
        return b;
    end
    return -1;
  endfunction

  function automatic logic [3:0] exp_be(int sz, int off, int p);
    int nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    int lm = (p == 0) ? 0 : (p == 1) ? 1 : 3;
    int pl = (p == 0) ? 1 : (p == 1) ? 3 : 15;
    return 4'(((((1 << nb) - 1) << (off & lm)) & pl));
  endfunction

  task automatic wr(input int b, input int w, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'((b << 1) | w); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] w0(logic [25:0] base, bit v, int code);
    return 32'(base & 26'h3FF8000) | (32'(v) << 4) | 32'(code & 15);
  endfunction
  function automatic logic [31:0] w1(int ws, int port, int tv, int tm);
    return 32'(ws & 31) | 32'((port & 3) << 8) | 32'((tv & 7) << 16) | 32'((tm & 7) << 20);
  endfunction

  task automatic prog(input int b, input logic [25:0] base, input bit v, input int code,
                      input int ws, input int port, input int tv, input int tm);
    wr(b, 0, w0(base, v, code));
    wr(b, 1, w1(ws, port, tv, tm));
    m_valid[b] = v; m_base[b] = base & 26'h3FF8000; m_code[b] = code;
    m_ws[b] = ws; m_port[b] = port; m_tval[b] = tv; m_tmask[b] = tm;
  endtask

  // one access; optional config write at the accept edge or inside the window
  task automatic run(input logic [25:0] a, input int t, input bit rd, input int sz,
                     input bit same_w, input bit mid_w, input logic [3:0] ca, input logic [31:0] cd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_type = 3'(t); req_read = rd; req_size = 2'(sz);
    if (same_w) begin cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = cd; end
    @(posedge clk);
    #1;
    req_valid = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    o_len = 0; o_ack_at = -1; o_acks = 0; o_sel = cs_sel; o_be = be; o_oe = oe;
    o_unm = unmapped; o_ack0 = ack; o_ready_bad = 1'b0; o_strobe_bad = 1'b0;
    while (cs_sel != 0 && o_len < 64) begin
      if (ack) begin o_acks++; o_ack_at = o_len; end
      if (req_ready) o_ready_bad = 1'b1;
      if (cs_sel != o_sel || be != o_be || oe != o_oe) o_strobe_bad = 1'b1;
      if (mid_w && o_len == 1) begin cfg_we = 1'b1; cfg_addr = ca; cfg_wdata = cd; end
      o_len++;
      @(negedge clk);
      cfg_we = 1'b0;
    end
  endtask

  task automatic judge(input logic [25:0] a, input int t, input bit rd, input int sz);
    int eb = exp_bank(a, t);
    if (eb < 0) begin
      chk(o_unm === 1'b1, "R5 unmapped flag", o_unm, 1);
      chk(o_sel == 0 && o_ack0 == 0 && o_len == 0, "R5 no select on miss", o_sel, 0);
    end else begin
      int ew = (m_ws[eb] > 30) ? 30 : m_ws[eb];
      chk(o_sel == 8'(1 << eb), "R2/R3 selected bank", o_sel, 1 << eb);
      chk(o_len == ew + 2 && o_acks == 1 && o_ack_at == ew + 1, "R4 length and ack", o_len, ew + 2);
      chk(o_oe == rd, "R6 output enable", o_oe, rd);
      chk(o_be == exp_be(sz, int'(a[1:0]), m_port[eb]), "R7 byte enables", o_be, exp_be(sz, int'(a[1:0]), m_port[eb]));
      chk(!o_ready_bad && !o_strobe_bad && !o_unm, "R8 busy and steady", o_ready_bad, 0);
    end
  endtask

  task automatic acc(input logic [25:0] a, input int t, input bit rd, input int sz);
    run(a, t, rd, sz, 0, 0, 4'd0, 32'd0);
    judge(a, t, rd, sz);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [25:0] lfsr;
    for (int b = 0; b < 8; b++) begin
      m_valid[b] = (b == 0); m_base[b] = '0; m_code[b] = (b == 0) ? 11 : 0;
      m_ws[b] = (b == 0) ? 30 : 0; m_port[b] = (b == 0) ? 2 : 0; m_tval[b] = 0; m_tmask[b] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cs_sel === 8'd0 && be === 4'd0 && oe === 1'b0, "R1 strobes idle", cs_sel, 0);
    chk(ack === 1'b0 && unmapped === 1'b0, "R1 no response", ack, 0);

    // R1: boot bank covers everything, any type, 30 waits
    for (int t = 0; t < 8; t++) begin
      acc(26'(t * 26'h0812345), t, t[0], 2);
      acc(26'h3FFFFFF - 26'(t), t, !t[0], t & 3);
    end

    // Near-exhaustive decode map with overlaps, type qualifiers and clamped size
    prog(0, 26'h0000000, 1, 0, 0, 2, 0, 0);
    prog(1, 26'h0000000, 1, 5, 1, 1, 0, 0);
    prog(2, 26'h0100000, 1, 3, 2, 0, 5, 7);
    prog(3, 26'h0400000, 1, 7, 3, 2, 1, 1);
    prog(4, 26'h0800000, 1, 2, 0, 2, 4, 4);
    prog(5, 26'h0800000, 1, 4, 0, 3, 0, 0);
    prog(6, 26'h2000000, 1, 10, 4, 1, 0, 2);
    prog(7, 26'h1000000, 1, 12, 1, 2, 7, 7);
    for (int b = 0; b < 8; b++) begin
      int sh = 15 + ((m_code[b] > 11) ? 11 : m_code[b]);
      logic [25:0] lo = 26'((m_base[b] >> sh) << sh);
      logic [25:0] sz = 26'((64'd1 << sh) - 1);
      for (int t = 0; t < 8; t++) begin
        acc(lo, t, t[1], t & 3);
        acc(lo + sz, t, !t[1], 2);
        acc(lo + sz + 26'd1, t, 1, 0);
        acc(lo - 26'd1, t, 0, 1);
      end
    end
    lfsr = 26'h1ACE5;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[24:0], lfsr[25] ^ lfsr[24] ^ lfsr[23] ^ lfsr[19]};
      acc(lfsr, i % 8, i[2], i % 4);
    end

    // R2: disabled bank is never selected
    prog(5, 26'h0800000, 0, 4, 0, 3, 0, 0);
    for (int t = 0; t < 7; t++) acc(26'h0860000, t, 1, 2);

    // R4: wait sweep including 31 (counts as 30)
    prog(0, 26'h0000000, 1, 0, 0, 2, 0, 0);
    for (int w = 0; w < 32; w++) begin
      wr(0, 1, w1(w, 2, 0, 0)); m_ws[0] = w;
      acc(26'h0000010, 0, 1, 2);
    end

    // R7: byte enables over size x offset x port
    for (int p = 0; p < 4; p++) begin
      wr(0, 1, w1(0, p, 0, 0)); m_ws[0] = 0; m_port[0] = p;
      for (int s = 0; s < 4; s++)
        for (int off = 0; off < 4; off++) acc(26'(off), s, s[0], s);
    end

    // R9: write at the accept edge uses the old descriptor
    prog(2, 26'h0100000, 1, 3, 3, 0, 0, 0);
    run(26'h0100004, 0, 1, 0, 1, 0, 4'((2 << 1) | 1), w1(20, 0, 0, 0));
    chk(o_sel == 8'h04 && o_len == 5, "R9 old wait at same edge", o_len, 5);
    m_ws[2] = 20;
    acc(26'h0100004, 0, 1, 0);
    chk(o_len == 22, "R9 new wait next access", o_len, 22);
    // R9: wait rewrite inside the window does not change the running access
    run(26'h0100008, 0, 0, 2, 0, 1, 4'((2 << 1) | 1), w1(0, 0, 0, 0));
    chk(o_len == 22 && o_acks == 1, "R9 in-flight length kept", o_len, 22);
    m_ws[2] = 0;
    acc(26'h0100008, 0, 0, 2);
    chk(o_len == 2, "R9 shortened wait applies after", o_len, 2);
    // R9: disabling a bank at the accept edge still hits it once
    run(26'h0100000, 0, 1, 2, 1, 0, 4'((2 << 1) | 0), w0(26'h0100000, 0, 3));
    chk(o_sel == 8'h04, "R9 disable at same edge uses old", o_sel, 8'h04);
    m_valid[2] = 0;
    acc(26'h0100000, 0, 1, 2);

    done = 1;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule